// File: doc/BRIEF.md
# Elastic Buffer Packet Phase Controller

This block runs the read side of a normally-half-full elastic buffer for the length of one received packet. The buffer storage, its pointers and its fill-level arithmetic live outside the block. The controller watches a packet-active input, the fill level and the empty and full flags. It decides when reading may start and when reading stops. It also decides what symbol appears on the output.

A packet passes through four phases, each named by whether writing and reading are active:
- **Idle**: neither is active.
- **Fill**: write only. Reads are held off until half of the buffer depth is occupied.
- **Run**: both write and read are active.
- **Drain**: read only. The controller keeps reading until the buffer is empty, then returns to idle.

If the buffer runs empty in the run phase, the controller places a fixed end-of-bad-data K-symbol on the output in place of the read data and pulses an underflow status. If a write is attempted while the buffer is full, the controller suppresses that write so one symbol is discarded, and it sets a sticky overflow status. That status clears when the next packet starts.

Top module: `ebuf_phase_ctrl`

## Requirements
- R1: After reset, `phase` is 2'b00, and `rd_en`, `out_valid`, `edb_sel`, `underflow`, `wr_drop` and `ovf_flag` are all 0.
- R2: `phase` encodes bit 1 = write active and bit 0 = read active: idle 2'b00, fill 2'b10, run 2'b11, drain 2'b01. In idle, a high `pkt_act` at a clock edge moves `phase` to fill.
- R3: In fill, `rd_en` and `out_valid` stay 0 while `level` is below DEPTH/2 (8 at default).
- R4: In fill with `pkt_act` high, a clock edge at which `level` >= DEPTH/2 moves `phase` to run.
- R5: In run with `buf_empty` low, `rd_en` is 1, `out_valid` is 1, `edb_sel` is 0 and `sym_out` equals `rd_data` in the same cycle.
- R6: In run with `buf_empty` high, `rd_en` is 0, `out_valid` is 1, `edb_sel` is 1, `sym_out` is the EDB code 10'b0011110011, and `underflow` is 1 for that cycle only.
- R7: A clock edge with `pkt_act` low, in fill or in run, moves `phase` to drain.
- R8: In drain, `rd_en` and `out_valid` both equal !`buf_empty`, and `underflow` and `edb_sel` stay 0. A clock edge with `buf_empty` high moves `phase` to idle.
- R9: When `wr_req` is 1 and `buf_full` is 1, `wr_drop` is 1 and `wr_ok` is 0 in the same cycle. Otherwise `wr_ok` equals `wr_req`.
- R10: `ovf_flag` becomes 1 on the clock edge after a cycle with `wr_drop` high. It holds until the idle-to-fill transition, which clears it, unless a drop happens in that same cycle.
- R11: For a packet written at one symbol per clock from an empty buffer, `out_valid` first rises in the cycle after the edge at which `level` reads DEPTH/2. That is about DEPTH/2 clocks after `pkt_act`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_act | input | 1 | Incoming packet is being written |
| level | input | LVL_W | Number of symbols held in the buffer |
| buf_empty | input | 1 | Buffer holds no symbols |
| buf_full | input | 1 | Buffer has no free slot |
| wr_req | input | 1 | Write attempt from the receive side |
| rd_data | input | SYM_W | Symbol at the buffer read port |
| wr_ok | output | 1 | Write permitted into the buffer |
| wr_drop | output | 1 | Incoming symbol discarded this cycle |
| ovf_flag | output | 1 | Sticky overflow status for the current packet |
| rd_en | output | 1 | Pop one symbol from the buffer |
| out_valid | output | 1 | `sym_out` carries a symbol |
| edb_sel | output | 1 | `sym_out` carries the EDB code |
| underflow | output | 1 | Run-phase underflow this cycle |
| sym_out | output | SYM_W | Output symbol |
| phase | output | 2 | Current phase, {write, read} |

## Verification
The bench targets the half-full boundary. A design that compares against DEPTH/2 with the wrong inequality starts reading one symbol early or one symbol late.

A packet that ends while still in fill must still reach drain. A controller that only leaves fill at half full would stay stuck there.

An empty buffer is treated differently in run and in drain. A design that inserts EDB during drain would emit a spurious underflow at the end of every packet.

The sticky overflow flag must survive later non-full cycles and clear only when the next packet starts. Clearing it too early, or never clearing it, shows up directly at `ovf_flag`.

// File: rtl/ebuf_phase_pkg.sv
package ebuf_phase_pkg;

   // Encoding is {write active, read active}
   typedef enum logic [1:0] {
      PH_IDLE  = 2'b00,
      PH_DRAIN = 2'b01,
      PH_FILL  = 2'b10,
      PH_RUN   = 2'b11
   } phase_t;

   localparam logic [9:0] EDB_K_DEFAULT = 10'b0011110011;

endpackage

// File: rtl/ebuf_phase_fsm.sv
module ebuf_phase_fsm
   import ebuf_phase_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   pkt_act,
   input  logic   half_hit,
   input  logic   buf_empty,
   output phase_t st,
   output logic   pkt_start
);

   phase_t st_nxt;

   always_comb begin
      st_nxt    = st;
      pkt_start = 1'b0;
      unique case (st)
         PH_IDLE: begin
            if (pkt_act) begin
               st_nxt    = PH_FILL;
               pkt_start = 1'b1;
            end
         end
         PH_FILL: begin
            if (!pkt_act)
               st_nxt = PH_DRAIN;
            else if (half_hit)
               st_nxt = PH_RUN;
         end
         PH_RUN: begin
            if (!pkt_act)
               st_nxt = PH_DRAIN;
         end
         PH_DRAIN: begin
            if (buf_empty)
               st_nxt = PH_IDLE;
         end
         default: st_nxt = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         st <= PH_IDLE;
      else
         st <= st_nxt;
   end

endmodule

// File: rtl/ebuf_out_mux.sv
module ebuf_out_mux
   import ebuf_phase_pkg::*;
#(
   parameter int unsigned      SYM_W    = 10,
   parameter logic [SYM_W-1:0] EDB_CODE = EDB_K_DEFAULT
)(
   input  phase_t           st,
   input  logic             buf_empty,
   input  logic [SYM_W-1:0] rd_data,
   output logic             rd_en,
   output logic             out_valid,
   output logic             edb_sel,
   output logic             underflow,
   output logic [SYM_W-1:0] sym_out
);

   logic rd_side;
   logic in_run;

   assign rd_side   = st[0];
   assign in_run    = (st == PH_RUN);

   assign rd_en     = rd_side && !buf_empty;
   assign edb_sel   = in_run && buf_empty;
   assign underflow = edb_sel;
   assign out_valid = rd_en || edb_sel;
   assign sym_out   = edb_sel ? EDB_CODE : rd_data;

endmodule

// File: rtl/ebuf_ovf_guard.sv
module ebuf_ovf_guard (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_req,
   input  logic buf_full,
   input  logic pkt_start,
   output logic wr_ok,
   output logic wr_drop,
   output logic ovf_flag
);

   assign wr_drop = wr_req && buf_full;
   assign wr_ok   = wr_req && !buf_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ovf_flag <= 1'b0;
      else if (wr_drop)
         ovf_flag <= 1'b1;
      else if (pkt_start)
         ovf_flag <= 1'b0;
   end

endmodule

// File: rtl/ebuf_phase_ctrl.sv
module ebuf_phase_ctrl
   import ebuf_phase_pkg::*;
#(
   parameter int unsigned      SYM_W    = 10,
   parameter int unsigned      DEPTH    = 16,
   parameter int unsigned      LVL_W    = $clog2(DEPTH + 1),
   parameter logic [SYM_W-1:0] EDB_CODE = EDB_K_DEFAULT
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pkt_act,
   input  logic [LVL_W-1:0] level,
   input  logic             buf_empty,
   input  logic             buf_full,
   input  logic             wr_req,
   input  logic [SYM_W-1:0] rd_data,
   output logic             wr_ok,
   output logic             wr_drop,
   output logic             ovf_flag,
   output logic             rd_en,
   output logic             out_valid,
   output logic             edb_sel,
   output logic             underflow,
   output logic [SYM_W-1:0] sym_out,
   output logic [1:0]       phase
);

   localparam int unsigned HALF = DEPTH / 2;

   if (DEPTH < 2 || (DEPTH % 2) != 0) begin : g_bad_depth
      $error("ebuf_phase_ctrl: DEPTH must be even and at least 2");
   end
   if ((2 ** LVL_W) <= DEPTH) begin : g_bad_lvl
      $error("ebuf_phase_ctrl: LVL_W cannot represent DEPTH");
   end
   if (SYM_W < 1) begin : g_bad_sym
      $error("ebuf_phase_ctrl: SYM_W must be positive");
   end

   phase_t st;
   logic   pkt_start;
   logic   half_hit;

   assign half_hit = (level >= LVL_W'(HALF));
   assign phase    = st;

   ebuf_phase_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .pkt_act   (pkt_act),
      .half_hit  (half_hit),
      .buf_empty (buf_empty),
      .st        (st),
      .pkt_start (pkt_start)
   );

   ebuf_out_mux #(
      .SYM_W    (SYM_W),
      .EDB_CODE (EDB_CODE)
   ) u_mux (
      .st        (st),
      .buf_empty (buf_empty),
      .rd_data   (rd_data),
      .rd_en     (rd_en),
      .out_valid (out_valid),
      .edb_sel   (edb_sel),
      .underflow (underflow),
      .sym_out   (sym_out)
   );

   ebuf_ovf_guard u_ovf (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_req    (wr_req),
      .buf_full  (buf_full),
      .pkt_start (pkt_start),
      .wr_ok     (wr_ok),
      .wr_drop   (wr_drop),
      .ovf_flag  (ovf_flag)
   );

endmodule

// File: rtl/ebuf_phase_chk.sv
module ebuf_phase_chk #(
   parameter int unsigned LVL_W = 5,
   parameter int unsigned DEPTH = 16
)(
   input logic             clk,
   input logic             rst_n,
   input logic             pkt_act,
   input logic [LVL_W-1:0] level,
   input logic             buf_empty,
   input logic             buf_full,
   input logic             wr_ok,
   input logic             wr_drop,
   input logic             ovf_flag,
   input logic             rd_en,
   input logic             underflow,
   input logic             edb_sel,
   input logic [1:0]       phase
);

   AST_IDLE_START: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == 2'b00 && pkt_act) |=> (phase == 2'b10)); // R2

   AST_NO_READ_IN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == 2'b10) |-> !rd_en); // R3

   AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      buf_empty |-> !rd_en); // R5

   AST_UNDERFLOW_RUN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      underflow |-> (phase == 2'b11 && edb_sel)); // R6

   AST_END_TO_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (phase[1] && !pkt_act) |=> (phase == 2'b01)); // R7

   AST_DRAIN_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == 2'b01 && buf_empty) |=> (phase == 2'b00)); // R8

   AST_NO_WRITE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ok |-> !buf_full); // R9

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      wr_drop |=> ovf_flag); // R10

   AST_FILL_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == 2'b10 && pkt_act && level >= LVL_W'(DEPTH / 2)) |=> (phase == 2'b11)); // R4

endmodule

bind ebuf_phase_ctrl ebuf_phase_chk #(
   .LVL_W (LVL_W),
   .DEPTH (DEPTH)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pkt_act   (pkt_act),
   .level     (level),
   .buf_empty (buf_empty),
   .buf_full  (buf_full),
   .wr_ok     (wr_ok),
   .wr_drop   (wr_drop),
   .ovf_flag  (ovf_flag),
   .rd_en     (rd_en),
   .underflow (underflow),
   .edb_sel   (edb_sel),
   .phase     (phase)
);

// File: tb/test_ebuf_phase_ctrl.sv
`timescale 1ns/1ps
module test_ebuf_phase_ctrl;

   localparam int SYM_W = 10;
   localparam int DEPTH = 16;
   localparam int LVL_W = $clog2(DEPTH + 1);
   localparam int HALF  = DEPTH / 2;
   localparam logic [SYM_W-1:0] EDB = 10'b0011110011;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             pkt_act = 1'b0;
   logic [LVL_W-1:0] level = '0;
   logic             buf_empty = 1'b1;
   logic             buf_full = 1'b0;
   logic             wr_req = 1'b0;
   logic [SYM_W-1:0] rd_data = '0;
   logic             wr_ok, wr_drop, ovf_flag, rd_en, out_valid, edb_sel, underflow;
   logic [SYM_W-1:0] sym_out;
   logic [1:0]       phase;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   ebuf_phase_ctrl #(.SYM_W(SYM_W), .DEPTH(DEPTH)) i_ebuf_phase_ctrl (
      .clk(clk), .rst_n(rst_n), .pkt_act(pkt_act), .level(level),
      .buf_empty(buf_empty), .buf_full(buf_full), .wr_req(wr_req),
      .rd_data(rd_data), .wr_ok(wr_ok), .wr_drop(wr_drop),
      .ovf_flag(ovf_flag), .rd_en(rd_en), .out_valid(out_valid),
      .edb_sel(edb_sel), .underflow(underflow), .sym_out(sym_out),
      .phase(phase)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // advance one edge; inputs change and outputs are sampled at the falling edge
   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      #0.5;
   endtask

   task automatic settle();
      #0.5;
   endtask

   task automatic t_reset();
      chk("R1", "phase", 32'(phase), 32'd0);
      chk("R1", "rd_en", 32'(rd_en), 32'd0);
      chk("R1", "out_valid", 32'(out_valid), 32'd0);
      chk("R1", "edb_sel", 32'(edb_sel), 32'd0);
      chk("R1", "underflow", 32'(underflow), 32'd0);
      chk("R1", "wr_drop", 32'(wr_drop), 32'd0);
      chk("R1", "ovf_flag", 32'(ovf_flag), 32'd0);
   endtask

   task automatic t_fill_and_run();
      pkt_act = 1'b1; level = '0; buf_empty = 1'b1;
      tick();
      chk("R2", "phase after start", 32'(phase), 32'h2);
      for (int k = 1; k < HALF; k++) begin
         level = LVL_W'(k); buf_empty = 1'b0;
         settle();
         chk("R3", "rd_en in fill", 32'(rd_en), 32'd0);
         chk("R3", "out_valid in fill", 32'(out_valid), 32'd0);
         tick();
         chk("R4", "still fill below half", 32'(phase), 32'h2);
      end
      level = LVL_W'(HALF);
      settle();
      chk("R11", "out_valid at half before edge", 32'(out_valid), 32'd0);
      tick();
      chk("R4", "phase at half", 32'(phase), 32'h3);
      rd_data = 10'h155;
      settle();
      chk("R11", "out_valid after half edge", 32'(out_valid), 32'd1);
      chk("R5", "rd_en run", 32'(rd_en), 32'd1);
      chk("R5", "sym_out run", 32'(sym_out), 32'h155);
      chk("R5", "edb_sel run", 32'(edb_sel), 32'd0);
      rd_data = 10'h2AA;
      settle();
      chk("R5", "sym_out run second", 32'(sym_out), 32'h2AA);
   endtask

   task automatic t_underflow();
      buf_empty = 1'b1; level = '0;
      settle();
      chk("R6", "rd_en underflow", 32'(rd_en), 32'd0);
      chk("R6", "edb_sel underflow", 32'(edb_sel), 32'd1);
      chk("R6", "sym_out EDB", 32'(sym_out), 32'(EDB));
      chk("R6", "underflow pulse", 32'(underflow), 32'd1);
      chk("R6", "out_valid underflow", 32'(out_valid), 32'd1);
      tick();
      buf_empty = 1'b0; level = LVL_W'(3); rd_data = 10'h0F0;
      settle();
      chk("R6", "underflow clears", 32'(underflow), 32'd0);
      chk("R6", "data back", 32'(sym_out), 32'h0F0);
   endtask

   task automatic t_drain();
      pkt_act = 1'b0;
      tick();
      chk("R7", "run to drain", 32'(phase), 32'h1);
      chk("R8", "rd_en drain", 32'(rd_en), 32'd1);
      chk("R8", "out_valid drain", 32'(out_valid), 32'd1);
      buf_empty = 1'b1; level = '0;
      settle();
      chk("R8", "out_valid drain empty", 32'(out_valid), 32'd0);
      chk("R8", "no underflow in drain", 32'(underflow), 32'd0);
      chk("R8", "no edb in drain", 32'(edb_sel), 32'd0);
      tick();
      chk("R8", "drain to idle", 32'(phase), 32'h0);
   endtask

   task automatic t_fill_abort();
      pkt_act = 1'b1; buf_empty = 1'b0; level = LVL_W'(2);
      tick();
      chk("R2", "restart fill", 32'(phase), 32'h2);
      pkt_act = 1'b0;
      tick();
      chk("R7", "fill to drain", 32'(phase), 32'h1);
      buf_empty = 1'b1; level = '0;
      tick();
      chk("R8", "abort drain to idle", 32'(phase), 32'h0);
   endtask

   task automatic t_overflow();
      wr_req = 1'b1; buf_full = 1'b0;
      settle();
      chk("R9", "wr_ok not full", 32'(wr_ok), 32'd1);
      chk("R9", "wr_drop not full", 32'(wr_drop), 32'd0);
      buf_full = 1'b1;
      settle();
      chk("R9", "wr_drop full", 32'(wr_drop), 32'd1);
      chk("R9", "wr_ok full", 32'(wr_ok), 32'd0);
      tick();
      buf_full = 1'b0; wr_req = 1'b0;
      settle();
      chk("R10", "flag set", 32'(ovf_flag), 32'd1);
      tick();
      tick();
      chk("R10", "flag holds", 32'(ovf_flag), 32'd1);
      pkt_act = 1'b1;
      tick();
      chk("R10", "flag cleared at packet start", 32'(ovf_flag), 32'd0);
      pkt_act = 1'b0;
      tick();
      tick();
   endtask

   initial begin
      #1;
      settle();
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      tick();
      chk("R1", "idle without packet", 32'(phase), 32'd0);
      t_fill_and_run();
      t_underflow();
      t_drain();
      t_fill_abort();
      t_overflow();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule